// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps a bank of eight one-bit lock flags that two independent ports, left and right, share. A port works with a flag only while its memory select input is held high (inactive) and its semaphore strobe is low. To claim a flag, a port writes a zero on its single data bit. It then reads the same flag address back: a zero means the port holds the flag, and a one means the port does not. A flag that nobody holds reads as one from both ports. The holder releases the flag by writing a one.

A request that loses, or that arrives while the other port holds the flag, is remembered. The waiting port receives the flag in the same clock edge that the holder releases it. When both ports claim the same free flag in the same cycle, an alternating tie-break gives the flag to exactly one of them. The left port wins the first tie after reset, and priority swaps after every tie. All inputs are sampled on the rising clock edge. Read data is registered, so it appears one cycle after the read strobe.

Top module: `sem_flag_bank`

## Requirements
- R1: After reset every flag is free, so a read of any address returns 1 on both ports, and no request is pending.
- R2: A write of data 0 to a free flag gives the flag to the writing port. From then on that port reads 0 at the flag's address and the other port reads 1.
- R3: A port's access is acted on only when its cs_n input is 1 and its sem_n input is 0. A write made with cs_n at 0, or with sem_n at 1, changes no flag.
- R4: A write is sem_n=0 with we_n=0. A read is sem_n=0 with we_n=1 and oe_n=0. The address selects flag number addr (0 to 7), and only the single data bit is used.
- R5: A write of data 1 by the holder frees the flag. A write of 1 by the port that does not hold the flag has no effect.
- R6: A write of 0 to a flag the other port holds is remembered. When the holder releases the flag, the waiting port holds it from the same clock edge.
- R7: When both ports write 0 to the same free flag in one cycle, exactly one port gets it and the other is left waiting. The left port wins the first such tie after reset, and the winning side alternates with each tie.
- R8: The eight flags are independent. An access to one address never changes the state of another flag.
- R9: dout shows the read result in the cycle after the read strobe. In every other cycle dout is 1, including a read made with oe_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left memory select, must be 1 for flag access |
| l_sem_n | input | 1 | Left semaphore strobe, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag address |
| l_din | input | 1 | Left write data: 0 claims, 1 releases |
| l_dout | output | 1 | Left registered read data |
| r_cs_n | input | 1 | Right memory select, must be 1 for flag access |
| r_sem_n | input | 1 | Right semaphore strobe, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag address |
| r_din | input | 1 | Right write data: 0 claims, 1 releases |
| r_dout | output | 1 | Right registered read data |

## Verification
A holder or waiting state stored wrongly becomes visible the next time either port reads that flag. The error shows as a zero on both ports, a one on both ports, or a handover that is missing after a release. It appears on dout one cycle after that read. A tie-break bit that is out of step shows on the next simultaneous claim, when the wrong side reads zero. After every scenario the bench reads all eight addresses, so a fault in any flag surfaces at the ports within a few cycles of the write that caused it.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    owner_e owner;
    logic   pend_l;
    logic   pend_r;
    logic   tie;
  } flag_st_t;

  // Next state of one flag, given this cycle's claims and releases.
  // rel_* is a raw write of 1; it only counts for the current holder.
  function automatic flag_st_t flag_next(
    input owner_e owner,
    input logic   pend_l,
    input logic   pend_r,
    input logic   req_l,
    input logic   rel_l,
    input logic   req_r,
    input logic   rel_r,
    input logic   prio_left
  );
    flag_st_t n;
    n = '{owner: owner, pend_l: pend_l, pend_r: pend_r, tie: 1'b0};
    case (owner)
      OWN_NONE: begin
        if (req_l && req_r) begin
          n.tie = 1'b1;
          if (prio_left) begin
            n.owner  = OWN_LEFT;
            n.pend_r = 1'b1;
          end else begin
            n.owner  = OWN_RIGHT;
            n.pend_l = 1'b1;
          end
        end else if (req_l) begin
          n.owner = OWN_LEFT;
        end else if (req_r) begin
          n.owner = OWN_RIGHT;
        end
      end
      OWN_LEFT: begin
        if (rel_l) begin
          if (pend_r || req_r) begin
            n.owner  = OWN_RIGHT;
            n.pend_r = 1'b0;
          end else begin
            n.owner = OWN_NONE;
          end
        end else if (req_r) begin
          n.pend_r = 1'b1;
        end
      end
      OWN_RIGHT: begin
        if (rel_r) begin
          if (pend_l || req_l) begin
            n.owner  = OWN_LEFT;
            n.pend_l = 1'b0;
          end else begin
            n.owner = OWN_NONE;
          end
        end else if (req_l) begin
          n.pend_l = 1'b1;
        end
      end
      default: n.owner = OWN_NONE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int ADDR_W = 3,
  localparam int NFLAGS = 1 << ADDR_W
) (
  input  logic              cs_n,
  input  logic              sem_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [NFLAGS-1:0] req_vec,
  output logic [NFLAGS-1:0] rel_vec,
  output logic              rd_en
);
  logic sel;
  logic wr;

  assign sel   = cs_n & ~sem_n;
  assign wr    = sel & ~we_n;
  assign rd_en = sel & we_n & ~oe_n;

  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    logic hit;
    assign hit        = (addr == ADDR_W'(f));
    assign req_vec[f] = wr & hit & ~din;
    assign rel_vec[f] = wr & hit & din;
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_l,
  input  logic rel_l,
  input  logic req_r,
  input  logic rel_r,
  input  logic prio_left,
  output logic own_l,
  output logic own_r,
  output logic pend_l,
  output logic pend_r,
  output logic tie
);
  owner_e   owner_q;
  logic     pend_l_q;
  logic     pend_r_q;
  flag_st_t nxt;

  always_comb begin
    nxt = flag_next(owner_q, pend_l_q, pend_r_q, req_l, rel_l, req_r, rel_r, prio_left);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= nxt.owner;
      pend_l_q <= nxt.pend_l;
      pend_r_q <= nxt.pend_r;
    end
  end

  assign own_l  = (owner_q == OWN_LEFT);
  assign own_r  = (owner_q == OWN_RIGHT);
  assign pend_l = pend_l_q;
  assign pend_r = pend_r_q;
  assign tie    = nxt.tie;
endmodule

// File: rtl/sem_tie_arb.sv
module sem_tie_arb #(
  parameter int NFLAGS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAGS-1:0] tie_vec,
  output logic              prio_left
);
  logic prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prio_q <= 1'b1;
    else if (|tie_vec) prio_q <= ~prio_q;
  end

  assign prio_left = prio_q;
endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_sem_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_din,
  output logic              l_dout,
  input  logic              r_cs_n,
  input  logic              r_sem_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_din,
  output logic              r_dout
);
  localparam int NFLAGS = 1 << ADDR_W;

  logic [NFLAGS-1:0] l_req, l_rel, r_req, r_rel;
  logic [NFLAGS-1:0] own_l, own_r, pend_l, pend_r, tie_vec;
  logic              l_rd, r_rd;
  logic              prio_left;
  logic              l_dout_q, r_dout_q;

  sem_port_decode #(.ADDR_W(ADDR_W)) u_dec_l (
    .cs_n(l_cs_n), .sem_n(l_sem_n), .we_n(l_we_n), .oe_n(l_oe_n),
    .addr(l_addr), .din(l_din),
    .req_vec(l_req), .rel_vec(l_rel), .rd_en(l_rd)
  );

  sem_port_decode #(.ADDR_W(ADDR_W)) u_dec_r (
    .cs_n(r_cs_n), .sem_n(r_sem_n), .we_n(r_we_n), .oe_n(r_oe_n),
    .addr(r_addr), .din(r_din),
    .req_vec(r_req), .rel_vec(r_rel), .rd_en(r_rd)
  );

  for (genvar f = 0; f < NFLAGS; f++) begin : g_cell
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .req_l(l_req[f]), .rel_l(l_rel[f]),
      .req_r(r_req[f]), .rel_r(r_rel[f]),
      .prio_left(prio_left),
      .own_l(own_l[f]), .own_r(own_r[f]),
      .pend_l(pend_l[f]), .pend_r(pend_r[f]),
      .tie(tie_vec[f])
    );
  end

  sem_tie_arb #(.NFLAGS(NFLAGS)) u_arb (
    .clk(clk), .rst_n(rst_n), .tie_vec(tie_vec), .prio_left(prio_left)
  );

  // Registered read-back: 0 means the reading port holds the flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_dout_q <= 1'b1;
      r_dout_q <= 1'b1;
    end else begin
      l_dout_q <= l_rd ? ~own_l[l_addr] : 1'b1;
      r_dout_q <= r_rd ? ~own_r[r_addr] : 1'b1;
    end
  end

  assign l_dout = l_dout_q;
  assign r_dout = r_dout_q;
endmodule

// File: rtl/sem_flag_bank_chk.sv
module sem_flag_bank_chk #(
  parameter int NFLAGS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_cs_n,
  input logic              r_cs_n,
  input logic              l_rd,
  input logic              r_rd,
  input logic              l_dout,
  input logic              r_dout,
  input logic              prio_left,
  input logic [NFLAGS-1:0] own_l,
  input logic [NFLAGS-1:0] own_r,
  input logic [NFLAGS-1:0] pend_l,
  input logic [NFLAGS-1:0] pend_r,
  input logic [NFLAGS-1:0] tie_vec,
  input logic [NFLAGS-1:0] l_rel,
  input logic [NFLAGS-1:0] r_rel
);
  p_never_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  p_pend_needs_holder_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_l & ~own_r) == '0) && ((pend_r & ~own_l) == '0));

  p_tie_swaps_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|tie_vec) |=> (prio_left != $past(prio_left)));

  p_cs_low_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !r_cs_n) |=> ($stable(own_l) && $stable(own_r)));

  p_idle_dout_l_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rd |=> l_dout);

  p_idle_dout_r_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !r_rd |=> r_dout);

  for (genvar f = 0; f < NFLAGS; f++) begin : g_flag
    p_tie_one_winner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tie_vec[f] |=> (own_l[f] ^ own_r[f]));

    p_handover_to_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_l[f] && l_rel[f] && pend_r[f]) |=> own_r[f]);

    p_handover_to_l_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (own_r[f] && r_rel[f] && pend_l[f]) |=> own_l[f]);
  end
endmodule

bind sem_flag_bank sem_flag_bank_chk #(.NFLAGS(NFLAGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .l_cs_n(l_cs_n), .r_cs_n(r_cs_n),
  .l_rd(l_rd), .r_rd(r_rd), .l_dout(l_dout), .r_dout(r_dout),
  .prio_left(prio_left), .own_l(own_l), .own_r(own_r),
  .pend_l(pend_l), .pend_r(pend_r), .tie_vec(tie_vec),
  .l_rel(l_rel), .r_rel(r_rel)
);

// File: tb/sem_flag_bank_test.sv
module sem_flag_bank_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1'b1, l_sem_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_din = 1'b1;
  logic r_cs_n = 1'b1, r_sem_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_din = 1'b1;
  logic [2:0] l_addr = '0, r_addr = '0;
  logic l_dout, r_dout;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Bench model: holder 0 none, 1 left, 2 right.
  int m_own[8];
  bit m_pl[8], m_pr[8];
  bit m_prio_l;
  int ties_seen;

  always #4 clk = ~clk;

  sem_flag_bank uut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_sem_n(l_sem_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout),
    .r_cs_n(r_cs_n), .r_sem_n(r_sem_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind: 0 idle, 1 write, 2 read, 3 write with cs_n low,
  //       4 write with sem_n high, 5 read with oe_n high
  task automatic drive(input bit left, input int kind, input int a, input bit d);
    logic cs, sm, we, oe;
    cs = 1'b1; sm = 1'b1; we = 1'b1; oe = 1'b1;
    case (kind)
      1: begin sm = 1'b0; we = 1'b0; end
      2: begin sm = 1'b0; oe = 1'b0; end
      3: begin cs = 1'b0; sm = 1'b0; we = 1'b0; end
      4: begin we = 1'b0; end
      5: begin sm = 1'b0; end
      default: ;
    endcase
    if (left) begin
      l_cs_n = cs; l_sem_n = sm; l_we_n = we; l_oe_n = oe; l_addr = 3'(a); l_din = d;
    end else begin
      r_cs_n = cs; r_sem_n = sm; r_we_n = we; r_oe_n = oe; r_addr = 3'(a); r_din = d;
    end
  endtask

  task automatic model_step(input bit wl, input int al, input bit dl,
                            input bit wr, input int ar, input bit dr);
    for (int f = 0; f < 8; f++) begin
      bit ql, qr, xl, xr;
      ql = wl && al == f && !dl;
      qr = wr && ar == f && !dr;
      xl = wl && al == f && dl;
      xr = wr && ar == f && dr;
      if (m_own[f] == 0) begin
        if (ql && qr) begin
          if (m_prio_l) begin m_own[f] = 1; m_pr[f] = 1'b1; end
          else begin m_own[f] = 2; m_pl[f] = 1'b1; end
          m_prio_l = !m_prio_l;
        end else if (ql) m_own[f] = 1;
        else if (qr) m_own[f] = 2;
      end else if (m_own[f] == 1) begin
        if (xl) begin
          if (m_pr[f] || qr) begin m_own[f] = 2; m_pr[f] = 1'b0; end
          else m_own[f] = 0;
        end else if (qr) m_pr[f] = 1'b1;
      end else begin
        if (xr) begin
          if (m_pl[f] || ql) begin m_own[f] = 1; m_pl[f] = 1'b0; end
          else m_own[f] = 0;
        end else if (ql) m_pl[f] = 1'b1;
      end
    end
  endtask

  task automatic cyc(input int kl, input int al, input bit dl,
                     input int kr, input int ar, input bit dr);
    @(negedge clk);
    drive(1'b1, kl, al, dl);
    drive(1'b0, kr, ar, dr);
    @(posedge clk);
    model_step(kl == 1, al, dl, kr == 1, ar, dr);
  endtask

  task automatic read_check(input int al, input int ar, input string tag);
    cyc(2, al, 1'b1, 2, ar, 1'b1);
    @(negedge clk);
    chk(l_dout == (m_own[al] != 1), tag, int'(l_dout), int'(m_own[al] != 1));
    chk(r_dout == (m_own[ar] != 2), tag, int'(r_dout), int'(m_own[ar] != 2));
  endtask

  task automatic sweep(input string tag);
    for (int a = 0; a < 8; a++) read_check(a, a, tag);
  endtask

  initial begin
    for (int f = 0; f < 8; f++) begin m_own[f] = 0; m_pl[f] = 1'b0; m_pr[f] = 1'b0; end
    m_prio_l = 1'b1;
    ties_seen = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: everything free after reset
    for (int a = 0; a < 8; a++) begin
      read_check(a, 7 - a, "R1 reset read");
      chk(l_dout && r_dout, "R1 both free", int'({l_dout, r_dout}), 3);
    end

    // R2 R4 R8: claim each flag, alternating ports; check all addresses each time
    for (int f = 0; f < 8; f++) begin
      if (f % 2 == 0) cyc(1, f, 1'b0, 0, 0, 1'b1);
      else            cyc(0, 0, 1'b1, 1, f, 1'b0);
      sweep("R2 R8 claim sweep");
    end

    // R5: non-owner writes 1 to every flag: nothing changes
    for (int f = 0; f < 8; f++) begin
      if (f % 2 == 0) cyc(0, 0, 1'b1, 1, f, 1'b1);
      else            cyc(1, f, 1'b1, 0, 0, 1'b1);
    end
    for (int f = 0; f < 8; f++) begin
      read_check(f, f, "R5 non-owner release ignored");
      chk(m_own[f] == (f % 2 == 0 ? 1 : 2), "R5 model holder", m_own[f], f % 2 == 0 ? 1 : 2);
    end

    // R5: owners release everything
    for (int f = 0; f < 8; f++) begin
      if (f % 2 == 0) cyc(1, f, 1'b1, 0, 0, 1'b1);
      else            cyc(0, 0, 1'b1, 1, f, 1'b1);
    end
    sweep("R5 release sweep");

    // R6: queued request, handover on release, both directions
    cyc(1, 5, 1'b0, 0, 0, 1'b1);
    cyc(0, 0, 1'b1, 1, 5, 1'b0);
    read_check(5, 5, "R6 waiter not granted early");
    chk(l_dout == 1'b0 && r_dout == 1'b1, "R6 left holds", int'({l_dout, r_dout}), 1);
    cyc(1, 5, 1'b1, 0, 0, 1'b1);
    read_check(5, 5, "R6 handover to right");
    chk(l_dout == 1'b1 && r_dout == 1'b0, "R6 right holds", int'({l_dout, r_dout}), 2);
    cyc(1, 5, 1'b0, 0, 0, 1'b1);
    cyc(0, 0, 1'b1, 1, 5, 1'b1);
    read_check(5, 5, "R6 handover to left");
    chk(l_dout == 1'b0 && r_dout == 1'b1, "R6 left holds again", int'({l_dout, r_dout}), 1);
    cyc(1, 5, 1'b1, 0, 0, 1'b1);
    sweep("R6 all free again");

    // R6: release and claim by the other port in the same cycle
    cyc(0, 0, 1'b1, 1, 2, 1'b0);
    cyc(1, 2, 1'b0, 1, 2, 1'b1);
    read_check(2, 2, "R6 same-cycle release and claim");
    chk(l_dout == 1'b0, "R6 same-cycle handover", int'(l_dout), 0);
    cyc(1, 2, 1'b1, 0, 0, 1'b1);

    // R7: simultaneous claims on each flag; winner alternates starting left
    for (int f = 0; f < 8; f++) begin
      bit left_wins;
      left_wins = (ties_seen % 2 == 0);
      cyc(1, f, 1'b0, 1, f, 1'b0);
      ties_seen++;
      read_check(f, f, "R7 tie sweep");
      chk(l_dout == !left_wins && r_dout == left_wins, "R7 alternating winner",
          int'({l_dout, r_dout}), left_wins ? 1 : 2);
      if (left_wins) cyc(1, f, 1'b1, 0, 0, 1'b1);
      else           cyc(0, 0, 1'b1, 1, f, 1'b1);
      read_check(f, f, "R7 loser gets flag after release");
      chk(l_dout != r_dout, "R7 exactly one holder", int'({l_dout, r_dout}), left_wins ? 2 : 1);
      if (left_wins) cyc(0, 0, 1'b1, 1, f, 1'b1);
      else           cyc(1, f, 1'b1, 0, 0, 1'b1);
    end
    sweep("R7 all free after ties");

    // R3: writes with cs_n low or sem_n high are ignored
    cyc(3, 2, 1'b0, 3, 6, 1'b0);
    cyc(4, 3, 1'b0, 4, 4, 1'b0);
    sweep("R3 ignored writes");
    chk(m_own[2] == 0 && m_own[3] == 0, "R3 model free", m_own[2], 0);

    // R9: read latency, idle value, oe_n high
    cyc(1, 1, 1'b0, 1, 6, 1'b0);
    cyc(2, 1, 1'b1, 2, 6, 1'b1);
    @(negedge clk);
    chk(l_dout == 1'b0 && r_dout == 1'b0, "R9 one-cycle read", int'({l_dout, r_dout}), 0);
    cyc(0, 0, 1'b1, 0, 0, 1'b1);
    @(negedge clk);
    chk(l_dout == 1'b1 && r_dout == 1'b1, "R9 idle dout", int'({l_dout, r_dout}), 3);
    cyc(5, 1, 1'b1, 5, 6, 1'b1);
    @(negedge clk);
    chk(l_dout == 1'b1 && r_dout == 1'b1, "R9 oe_n high reads 1", int'({l_dout, r_dout}), 3);
    sweep("R8 only flags 1 and 6 held");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule